// File: doc/BRIEF.md
# Reloadable Microsecond Timing-Sync Counter

This block keeps a 64-bit free-running time base. The count advances by one on each 1 MHz tick enable. Software can replace the running value. It writes the new value as two 32-bit halves into a low load register and a high load register. The count only changes when the top bit of the high load register falls from 1 to 0. Software therefore writes the high half once with its top bit set, and then again with that bit clear.

The load takes the register contents that were held before the triggering write. This means the value that carries the trigger bit's falling edge never has its own data bits loaded. The top bit of the high register serves only as the trigger, so bit 63 of a loaded value is always 0. The live value is also offered as two read-only halves. When the low half is read, the high half is captured at the same moment, so a low read followed by a high read gives one coherent 64-bit snapshot.

The counter is built from fixed-width segments joined by a carry chain. The segment width is a parameter, which lets the logic depth be traded against the number of segments.

Top module: `tsf_timer`

## Requirements
- R1: While reset is asserted, and right after it is released, the live count, both load registers and the captured high half all read 0.
- R2: When no reload happens, each cycle with `us_tick` high raises the count by exactly one. This holds across every segment boundary, and the count wraps from all-ones to 0.
- R3: When no reload happens and `us_tick` is low, the count keeps its value.
- R4: A write to the low load register alone never changes the count.
- R5: A reload happens only in a cycle where `hi_wr` is high, the stored high register has bit 31 (its MSB) at 1, and `hi_wdata` bit 31 is 0. A high write that goes 0→1, 1→1 or 0→0 on that bit does not reload.
- R6: On a reload, the next count is {1'b0, high register bits 30:0, low register bits 31:0}. Both registers are taken as they stood before the triggering cycle, so a low or high write in that same cycle does not reach the loaded value.
- R7: When a reload and `us_tick` fall in the same cycle, the count becomes exactly the loaded value, with no increment.
- R8: `rd_lo_data` always shows the live low half. A cycle with `rd_lo` high captures the live high half into `rd_hi_data`. `rd_hi_data` then holds that value until the next `rd_lo` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle enable per microsecond |
| lo_wr | input | 1 | Write strobe, low load register |
| lo_wdata | input | REG_W (32) | Low load data |
| hi_wr | input | 1 | Write strobe, high load register |
| hi_wdata | input | REG_W (32) | High load data; MSB is the reload trigger |
| rd_lo | input | 1 | Low-half read strobe; captures the high half |
| tsf_count | output | 2*REG_W (64) | Live count |
| rd_lo_data | output | REG_W (32) | Live low half |
| rd_hi_data | output | REG_W (32) | High half captured at the last low read |

## Verification
The bench builds the block with REG_W = 8 and SEG_W = 4. This gives a 16-bit count made of four segments. With this size, the wrap from all-ones to zero can be reached by ticking from a loaded value in about 32k cycles. Loads such as 0x00FF and 0x12FF sit right at segment and half boundaries, so the carry chain and snapshot coherence are both exercised. Every trigger-bit transition pattern is driven, and so are same-cycle collisions of a reload with a tick or with a low write.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

  // Action the counter takes in a cycle; reload outranks a tick.
  typedef enum logic [1:0] {
    TSF_HOLD = 2'd0,
    TSF_STEP = 2'd1,
    TSF_LOAD = 2'd2
  } tsf_op_e;

  function automatic tsf_op_e tsf_pick_op(input logic load, input logic tick);
    if (load)      return TSF_LOAD;
    else if (tick) return TSF_STEP;
    else           return TSF_HOLD;
  endfunction

endpackage

// File: rtl/tsf_load_regs.sv
module tsf_load_regs #(
  parameter int REG_W = 32,
  localparam int CNT_W = 2 * REG_W,
  localparam int MSB   = REG_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lo_wr,
  input  logic [REG_W-1:0] lo_wdata,
  input  logic             hi_wr,
  input  logic [REG_W-1:0] hi_wdata,
  output logic [REG_W-1:0] lo_q,
  output logic [REG_W-1:0] hi_q,
  output logic             load_fire,
  output logic [CNT_W-1:0] load_val
);

  logic [REG_W-1:0] lo_d, hi_d;

  // Next-state for the holding registers.
  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (lo_wr) lo_d = lo_wdata;
    if (hi_wr) hi_d = hi_wdata;
  end

  // Trigger: a write that takes the stored MSB from 1 down to 0.
  always_comb begin
    load_fire = hi_wr & hi_q[MSB] & ~hi_wdata[MSB];
    load_val  = {1'b0, hi_q[MSB-1:0], lo_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

endmodule

// File: rtl/tsf_counter.sv
module tsf_counter
  import tsf_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int SEG_W = 16,
  localparam int NSEG = CNT_W / SEG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] cnt_q, cnt_inc, cnt_d;
  logic [NSEG:0]    carry;
  tsf_op_e          op;

  // Segmented incrementer: each segment adds the carry from below.
  assign carry[0] = 1'b1;
  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [SEG_W-1:0] seg_q;
    assign seg_q = cnt_q[s*SEG_W +: SEG_W];
    assign cnt_inc[s*SEG_W +: SEG_W] = seg_q + {{(SEG_W-1){1'b0}}, carry[s]};
    assign carry[s+1] = carry[s] & (&seg_q);
  end

  always_comb begin
    op = tsf_pick_op(load, tick);
    unique case (op)
      TSF_LOAD: cnt_d = load_val;
      TSF_STEP: cnt_d = cnt_inc;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // Carry out of the top segment is the wrap and is dropped.
  logic unused_carry;
  assign unused_carry = carry[NSEG];

endmodule

// File: rtl/tsf_snapshot.sv
module tsf_snapshot #(
  parameter int REG_W = 32,
  localparam int CNT_W = 2 * REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_lo,
  input  logic [CNT_W-1:0] count,
  output logic [REG_W-1:0] rd_lo_data,
  output logic [REG_W-1:0] rd_hi_data
);

  logic [REG_W-1:0] hi_cap_q, hi_cap_d;

  always_comb begin
    hi_cap_d = hi_cap_q;
    if (rd_lo) hi_cap_d = count[CNT_W-1:REG_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cap_q <= '0;
    else        hi_cap_q <= hi_cap_d;
  end

  assign rd_lo_data = count[REG_W-1:0];
  assign rd_hi_data = hi_cap_q;

endmodule

// File: rtl/tsf_timer.sv
module tsf_timer #(
  parameter int REG_W = 32,
  parameter int SEG_W = 16,
  localparam int CNT_W = 2 * REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_tick,
  input  logic             lo_wr,
  input  logic [REG_W-1:0] lo_wdata,
  input  logic             hi_wr,
  input  logic [REG_W-1:0] hi_wdata,
  input  logic             rd_lo,
  output logic [CNT_W-1:0] tsf_count,
  output logic [REG_W-1:0] rd_lo_data,
  output logic [REG_W-1:0] rd_hi_data
);

  logic [REG_W-1:0] lo_q, hi_q;
  logic             load_fire;
  logic [CNT_W-1:0] load_val;

  tsf_load_regs #(.REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .lo_wr(lo_wr), .lo_wdata(lo_wdata),
    .hi_wr(hi_wr), .hi_wdata(hi_wdata),
    .lo_q(lo_q), .hi_q(hi_q),
    .load_fire(load_fire), .load_val(load_val)
  );

  tsf_counter #(.CNT_W(CNT_W), .SEG_W(SEG_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .tick(us_tick), .load(load_fire), .load_val(load_val),
    .count(tsf_count)
  );

  tsf_snapshot #(.REG_W(REG_W)) u_snap (
    .clk(clk), .rst_n(rst_n),
    .rd_lo(rd_lo), .count(tsf_count),
    .rd_lo_data(rd_lo_data), .rd_hi_data(rd_hi_data)
  );

endmodule

// File: rtl/tsf_timer_chk.sv
module tsf_timer_chk #(
  parameter int REG_W = 32,
  localparam int CNT_W = 2 * REG_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             us_tick,
  input logic             lo_wr,
  input logic             hi_wr,
  input logic [REG_W-1:0] hi_wdata,
  input logic             rd_lo,
  input logic [CNT_W-1:0] tsf_count,
  input logic [REG_W-1:0] rd_hi_data,
  input logic [REG_W-1:0] lo_q,
  input logic [REG_W-1:0] hi_q
);

  logic trig;
  assign trig = hi_wr & hi_q[REG_W-1] & ~hi_wdata[REG_W-1];

  // R2
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && us_tick) |=> tsf_count == $past(tsf_count) + 1'b1);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && !us_tick) |=> $stable(tsf_count));

  // R4
  lo_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr && !hi_wr && !us_tick) |=> $stable(tsf_count));

  // R6 R7
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> tsf_count == {1'b0, $past(hi_q[REG_W-2:0]), $past(lo_q)});

  // R8
  snap_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> rd_hi_data == $past(tsf_count[CNT_W-1:REG_W]));

  // R8
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_lo |=> $stable(rd_hi_data));

endmodule

bind tsf_timer tsf_timer_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
  .lo_wr(lo_wr), .hi_wr(hi_wr), .hi_wdata(hi_wdata), .rd_lo(rd_lo),
  .tsf_count(tsf_count), .rd_hi_data(rd_hi_data),
  .lo_q(lo_q), .hi_q(hi_q)
);

// File: tb/tsf_timer_bench.sv
module tsf_timer_bench;

  localparam int RW = 8;
  localparam int CW = 2 * RW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          us_tick = 1'b0, lo_wr = 1'b0, hi_wr = 1'b0, rd_lo = 1'b0;
  logic [RW-1:0] lo_wdata = '0, hi_wdata = '0;
  logic [CW-1:0] tsf_count;
  logic [RW-1:0] rd_lo_data, rd_hi_data;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  tsf_timer #(.REG_W(RW), .SEG_W(4)) u_tsf_timer (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
    .lo_wr(lo_wr), .lo_wdata(lo_wdata), .hi_wr(hi_wr), .hi_wdata(hi_wdata),
    .rd_lo(rd_lo), .tsf_count(tsf_count),
    .rd_lo_data(rd_lo_data), .rd_hi_data(rd_hi_data)
  );

  // {hi, lo} load pairs; expected = {0, hi[6:0], lo}
  localparam logic [CW-1:0] VEC [4] = '{16'hABCD, 16'hFFFF, 16'h8000, 16'h3C5A};

  task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge: drive, let one posedge pass, sample at next negedge.
  task automatic step(input logic lw, input logic [RW-1:0] ld,
                      input logic hw, input logic [RW-1:0] hd,
                      input logic tk, input logic rd);
    lo_wr = lw; lo_wdata = ld; hi_wr = hw; hi_wdata = hd; us_tick = tk; rd_lo = rd;
    @(negedge clk);
    lo_wr = 1'b0; hi_wr = 1'b0; us_tick = 1'b0; rd_lo = 1'b0;
  endtask

  // Low write, high write with MSB set, then trigger write with junk data bits.
  task automatic do_load(input logic [RW-1:0] lo, input logic [RW-1:0] hi, input logic tk);
    step(1'b1, lo, 1'b0, '0, 1'b0, 1'b0);
    step(1'b0, '0, 1'b1, {1'b1, hi[RW-2:0]}, 1'b0, 1'b0);
    step(1'b0, '0, 1'b1, {1'b0, ~hi[RW-2:0]}, tk, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [CW-1:0] v;
    @(negedge clk);
    check("R1 count in reset", tsf_count, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 count after reset", tsf_count, '0);
    check("R1 captured hi after reset", {8'h00, rd_hi_data}, '0);
    // R1: load regs zero: a 0->0 trigger-bit write must not load
    step(1'b0, '0, 1'b1, 8'h00, 1'b0, 1'b0);
    check("R1 R5 no trigger from reset regs", tsf_count, '0);

    for (int i = 0; i < 4; i++) begin
      v = VEC[i];
      do_load(v[RW-1:0], v[CW-1:RW], 1'b0);
      check("R6 table load", tsf_count, {1'b0, v[CW-2:0]});
    end

    // R3 hold, R2 step
    step(1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
    check("R3 hold without tick", tsf_count, 16'h3C5A);
    step(1'b0, '0, 1'b0, '0, 1'b1, 1'b0);
    check("R2 single step", tsf_count, 16'h3C5B);

    // R4 low only
    step(1'b1, 8'h77, 1'b0, '0, 1'b0, 1'b0);
    check("R4 low write alone", tsf_count, 16'h3C5B);

    // R5 non-falling patterns
    step(1'b0, '0, 1'b1, 8'h05, 1'b0, 1'b0);
    check("R5 0->0 no reload", tsf_count, 16'h3C5B);
    step(1'b0, '0, 1'b1, 8'h86, 1'b0, 1'b0);
    check("R5 0->1 no reload", tsf_count, 16'h3C5B);
    step(1'b0, '0, 1'b1, 8'h91, 1'b0, 1'b0);
    check("R5 1->1 no reload", tsf_count, 16'h3C5B);
    step(1'b0, '0, 1'b1, 8'h00, 1'b0, 1'b0);
    check("R5 1->0 reload", tsf_count, 16'h1177);

    // R6 same-cycle low write uses old low value
    step(1'b1, 8'h11, 1'b1, 8'h85, 1'b0, 1'b0);
    step(1'b1, 8'h22, 1'b1, 8'h00, 1'b0, 1'b0);
    check("R6 old low value used", tsf_count, 16'h0511);

    // R7 reload beats tick
    do_load(8'h40, 8'h02, 1'b1);
    check("R7 load over tick", tsf_count, 16'h0240);

    // R2 carry across segments
    do_load(8'hFF, 8'h00, 1'b0);
    step(1'b0, '0, 1'b0, '0, 1'b1, 1'b0);
    check("R2 carry across segments", tsf_count, 16'h0100);

    // R8 coherent snapshot
    do_load(8'hFF, 8'h12, 1'b0);
    lo_wr = 1'b0; hi_wr = 1'b0; us_tick = 1'b1; rd_lo = 1'b1;
    #1;
    check("R8 live low half", {8'h00, rd_lo_data}, 16'h00FF);
    @(negedge clk);
    us_tick = 1'b0; rd_lo = 1'b0;
    check("R8 captured hi", {8'h00, rd_hi_data}, 16'h0012);
    check("R8 count moved on", tsf_count, 16'h1300);
    step(1'b0, '0, 1'b0, '0, 1'b1, 1'b0);
    check("R8 hi held without read", {8'h00, rd_hi_data}, 16'h0012);

    // R2 wrap
    do_load(8'hFE, 8'h7F, 1'b0);
    us_tick = 1'b1;
    for (int k = 0; k < 32769; k++) @(negedge clk);
    check("R2 reach all ones", tsf_count, 16'hFFFF);
    @(negedge clk);
    us_tick = 1'b0;
    check("R2 wrap to zero", tsf_count, 16'h0000);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule